// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control state machine of a processor datapath that spends several clock cycles on each instruction. The only datapath input is the 6-bit major opcode held in the instruction register. From its current state and that opcode it drives a Moore-style control word. The word holds the program-counter write enables, memory select and strobes, instruction-register load, register-file write controls, ALU operand selects, ALU operation class and PC source.

Every instruction begins with the same two cycles. The first is a fetch that also advances the PC by 4. The second is a decode cycle that reads the source registers and, speculatively, adds the shifted immediate to the new PC as a possible branch target. After decode the sequencer follows a path chosen by the opcode: three cycles in total for a branch-if-equal, four for a register-to-register ALU operation or a store, five for a load. An unrecognised opcode goes back to fetch straight after decode. A separate decoder outside this block turns the function field into the actual ALU operation. Reset is synchronous and active high.

Top module: `mc_seq_ctrl`

## Requirements
- R1: While `rst` is high, every control output is 0. On the first cycle after `rst` goes low the fetch word is driven. A reset taken in the middle of an instruction abandons it.
- R2: Fetch drives `mem_rd=1`, `ir_wr=1`, `pc_wr=1`, `addr_sel=0` (PC addresses memory), `alu_a_sel=0` (PC), `alu_b_sel=01` (constant 4), `alu_op=00` (add) and `pc_src=0` (ALU result). All other outputs are 0.
- R3: The cycle after fetch is decode, for every opcode. It drives `alu_a_sel=0`, `alu_b_sel=11` (sign-extended immediate shifted left by 2) and `alu_op=00`. All other outputs are 0.
- R4: Opcode 000000 (ALU type) takes 4 cycles. The third cycle drives `alu_a_sel=1` (register A), `alu_b_sel=00` (register B) and `alu_op=10` (use function field). The fourth drives `reg_wr=1`, `dst_sel=1` (rd) and `wb_from_mem=0`.
- R5: Opcode 000100 (branch if equal) takes 3 cycles. The third cycle drives `alu_a_sel=1`, `alu_b_sel=00`, `alu_op=01` (subtract), `pc_wr_cond=1` and `pc_src=1` (ALUOut), with `pc_wr=0`.
- R6: For opcodes 100011 and 101011 the third cycle computes an address with `alu_a_sel=1`, `alu_b_sel=10` (sign-extended immediate, unshifted) and `alu_op=00`. In that cycle the opcode picks the fourth state: 101011 gives the store write, and any other value gives the load read.
- R7: Opcode 101011 (store) takes 4 cycles. The fourth drives `mem_wr=1` and `addr_sel=1` (ALUOut addresses memory).
- R8: Opcode 100011 (load) takes 5 cycles. The fourth drives `mem_rd=1` and `addr_sel=1`. The fifth drives `reg_wr=1`, `wb_from_mem=1` and `dst_sel=0` (rt).
- R9: In every state, each output that the state does not name is 0. `mem_rd` and `mem_wr` are never 1 together.
- R10: Any opcode other than the four above returns to fetch right after decode, so the instruction takes 2 cycles.
- R11: The opcode is used only in the decode cycle and the address cycle. Its value in any other cycle does not change the sequence or the outputs.
- R12: After the last cycle of every path the next cycle is fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Major opcode from the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the ALU zero flag |
| addr_sel | output | 1 | Memory address select: 0 PC, 1 ALUOut |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data select: 0 ALUOut, 1 memory data register |
| dst_sel | output | 1 | Destination register select: 0 rt, 1 rd |
| reg_wr | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU operand A select: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU operand B select: 00 B, 01 four, 10 immediate, 11 immediate shifted by 2 |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALUOut |

## Verification
Two duties share one cycle in two places. In fetch, the memory read into the instruction register coincides with the ALU incrementing the PC. In branch completion, the ALU performs the equality subtraction while the PC is offered the target that decode saved in ALUOut. Both are provoked by walking every one of the 64 opcodes through its full path, followed by back-to-back runs of the four known instructions. Each cycle is judged by comparing the entire control word with one built in the bench from the cycle index and the instruction kind, so a missing or extra strobe in a shared cycle shows up as a mismatch. The opcode is scrambled in every cycle where it must be ignored, and resets are dropped into the middle of a load and a branch.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_MEMRD  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_MEMWR  = 4'd5,
    ST_EXEC   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRANCH = 4'd8
  } seq_state_e;

  localparam int NUM_STATES = 9;

  typedef enum logic [2:0] {
    PATH_NONE   = 3'd0,
    PATH_ALU    = 3'd1,
    PATH_LOAD   = 3'd2,
    PATH_STORE  = 3'd3,
    PATH_BRANCH = 3'd4
  } path_e;

  // operand B sources
  localparam logic [1:0] BSRC_REG    = 2'b00;
  localparam logic [1:0] BSRC_FOUR   = 2'b01;
  localparam logic [1:0] BSRC_IMM    = 2'b10;
  localparam logic [1:0] BSRC_IMM_SH = 2'b11;

  // ALU operation classes
  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNCT = 2'b10;

  localparam logic ASRC_PC     = 1'b0;
  localparam logic ASRC_REGA   = 1'b1;
  localparam logic ADDR_PC     = 1'b0;
  localparam logic ADDR_ALUOUT = 1'b1;
  localparam logic DST_RT      = 1'b0;
  localparam logic DST_RD      = 1'b1;
  localparam logic PCSEL_ALU   = 1'b0;
  localparam logic PCSEL_HELD  = 1'b1;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_from_mem;
    logic       dst_sel;
    logic       reg_wr;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       pc_src;
  } ctl_word_t;

  function automatic ctl_word_t ctl_idle();
    ctl_word_t w;
    w = '0;
    return w;
  endfunction

  // total cycles an instruction spends, fetch and decode included
  function automatic int unsigned path_cycles(path_e p);
    case (p)
      PATH_ALU:    return 4;
      PATH_LOAD:   return 5;
      PATH_STORE:  return 4;
      PATH_BRANCH: return 3;
      default:     return 2;
    endcase
  endfunction

  // first state after decode for a given path
  function automatic seq_state_e path_entry(path_e p);
    case (p)
      PATH_ALU:    return ST_EXEC;
      PATH_LOAD:   return ST_ADDR;
      PATH_STORE:  return ST_ADDR;
      PATH_BRANCH: return ST_BRANCH;
      default:     return ST_FETCH;
    endcase
  endfunction

  function automatic logic is_path_last(seq_state_e s);
    return (s == ST_RWB) || (s == ST_LDWB) || (s == ST_MEMWR) || (s == ST_BRANCH);
  endfunction

endpackage

// File: rtl/seq_op_classify.sv
module seq_op_classify
  import seqctl_pkg::*;
#(
  parameter int          OPW       = 6,
  parameter logic [5:0]  OP_ALU    = 6'b000000,
  parameter logic [5:0]  OP_LOAD   = 6'b100011,
  parameter logic [5:0]  OP_STORE  = 6'b101011,
  parameter logic [5:0]  OP_BRANCH = 6'b000100
) (
  input  logic [OPW-1:0] opcode,
  output path_e          path
);
  localparam int NCODES = 4;
  localparam logic [NCODES*OPW-1:0] CODES =
    {OP_BRANCH[OPW-1:0], OP_STORE[OPW-1:0], OP_LOAD[OPW-1:0], OP_ALU[OPW-1:0]};

  logic [NCODES-1:0] hit;

  for (genvar k = 0; k < NCODES; k++) begin : g_match
    assign hit[k] = (opcode == CODES[k*OPW +: OPW]);
  end

  always_comb begin
    path = PATH_NONE;
    if (hit[0])      path = PATH_ALU;
    else if (hit[1]) path = PATH_LOAD;
    else if (hit[2]) path = PATH_STORE;
    else if (hit[3]) path = PATH_BRANCH;
  end
endmodule

// File: rtl/seq_next_state.sv
module seq_next_state
  import seqctl_pkg::*;
(
  input  seq_state_e cur,
  input  path_e      path,
  output seq_state_e nxt,
  output logic       last_cycle
);
  always_comb begin
    nxt = ST_FETCH;
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = path_entry(path);
      ST_ADDR:   nxt = (path == PATH_STORE) ? ST_MEMWR : ST_MEMRD;
      ST_MEMRD:  nxt = ST_LDWB;
      ST_EXEC:   nxt = ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end

  assign last_cycle = is_path_last(cur) || ((cur == ST_DECODE) && (path == PATH_NONE));
endmodule

// File: rtl/seq_state_reg.sv
module seq_state_reg
  import seqctl_pkg::*;
#(
  parameter bit ONEHOT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  seq_state_e nxt,
  output seq_state_e cur
);
  if (ONEHOT) begin : g_onehot
    logic [NUM_STATES-1:0] oh_q, oh_d;

    always_comb begin
      for (int i = 0; i < NUM_STATES; i++) begin
        oh_d[i] = (nxt == seq_state_e'(4'(i)));
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        oh_q <= '0;
        oh_q[0] <= 1'b1;
      end else begin
        oh_q <= oh_d;
      end
    end

    always_comb begin
      cur = ST_FETCH;
      for (int i = 0; i < NUM_STATES; i++) begin
        if (oh_q[i]) cur = seq_state_e'(4'(i));
      end
    end
  end else begin : g_binary
    seq_state_e st_q;

    always_ff @(posedge clk) begin
      if (rst) st_q <= ST_FETCH;
      else     st_q <= nxt;
    end

    assign cur = st_q;
  end
endmodule

// File: rtl/seq_ctl_decode.sv
module seq_ctl_decode
  import seqctl_pkg::*;
(
  input  logic       rst,
  input  seq_state_e cur,
  output ctl_word_t  ctl
);
  ctl_word_t w;

  always_comb begin
    w = ctl_idle();
    case (cur)
      ST_FETCH: begin
        w.mem_rd    = 1'b1;
        w.ir_wr     = 1'b1;
        w.addr_sel  = ADDR_PC;
        w.alu_a_sel = ASRC_PC;
        w.alu_b_sel = BSRC_FOUR;
        w.alu_op    = AOP_ADD;
        w.pc_src    = PCSEL_ALU;
        w.pc_wr     = 1'b1;
      end
      ST_DECODE: begin
        w.alu_a_sel = ASRC_PC;
        w.alu_b_sel = BSRC_IMM_SH;
        w.alu_op    = AOP_ADD;
      end
      ST_ADDR: begin
        w.alu_a_sel = ASRC_REGA;
        w.alu_b_sel = BSRC_IMM;
        w.alu_op    = AOP_ADD;
      end
      ST_MEMRD: begin
        w.mem_rd   = 1'b1;
        w.addr_sel = ADDR_ALUOUT;
      end
      ST_LDWB: begin
        w.reg_wr      = 1'b1;
        w.wb_from_mem = 1'b1;
        w.dst_sel     = DST_RT;
      end
      ST_MEMWR: begin
        w.mem_wr   = 1'b1;
        w.addr_sel = ADDR_ALUOUT;
      end
      ST_EXEC: begin
        w.alu_a_sel = ASRC_REGA;
        w.alu_b_sel = BSRC_REG;
        w.alu_op    = AOP_FUNCT;
      end
      ST_RWB: begin
        w.reg_wr      = 1'b1;
        w.wb_from_mem = 1'b0;
        w.dst_sel     = DST_RD;
      end
      ST_BRANCH: begin
        w.alu_a_sel  = ASRC_REGA;
        w.alu_b_sel  = BSRC_REG;
        w.alu_op     = AOP_SUB;
        w.pc_wr_cond = 1'b1;
        w.pc_src     = PCSEL_HELD;
      end
      default: w = ctl_idle();
    endcase
  end

  // outputs stay deasserted for as long as reset is held
  assign ctl = rst ? ctl_idle() : w;
endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import seqctl_pkg::*;
#(
  parameter int         OPW       = 6,
  parameter logic [5:0] OP_ALU    = 6'b000000,
  parameter logic [5:0] OP_LOAD   = 6'b100011,
  parameter logic [5:0] OP_STORE  = 6'b101011,
  parameter logic [5:0] OP_BRANCH = 6'b000100,
  parameter bit         ONEHOT    = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic           pc_wr,
  output logic           pc_wr_cond,
  output logic           addr_sel,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           ir_wr,
  output logic           wb_from_mem,
  output logic           dst_sel,
  output logic           reg_wr,
  output logic           alu_a_sel,
  output logic [1:0]     alu_b_sel,
  output logic [1:0]     alu_op,
  output logic           pc_src
);
  seq_state_e cur_st;
  seq_state_e nxt_st;
  path_e      dec_path;
  ctl_word_t  ctl_w;

  // named internal events
  logic at_fetch;
  logic at_decode;
  logic path_end;

  seq_op_classify #(
    .OPW(OPW), .OP_ALU(OP_ALU), .OP_LOAD(OP_LOAD),
    .OP_STORE(OP_STORE), .OP_BRANCH(OP_BRANCH)
  ) u_cls (
    .opcode(opcode),
    .path  (dec_path)
  );

  seq_next_state u_nxt (
    .cur       (cur_st),
    .path      (dec_path),
    .nxt       (nxt_st),
    .last_cycle(path_end)
  );

  seq_state_reg #(.ONEHOT(ONEHOT)) u_st (
    .clk(clk),
    .rst(rst),
    .nxt(nxt_st),
    .cur(cur_st)
  );

  seq_ctl_decode u_dec (
    .rst(rst),
    .cur(cur_st),
    .ctl(ctl_w)
  );

  assign at_fetch  = (cur_st == ST_FETCH);
  assign at_decode = (cur_st == ST_DECODE);

  assign pc_wr       = ctl_w.pc_wr;
  assign pc_wr_cond  = ctl_w.pc_wr_cond;
  assign addr_sel    = ctl_w.addr_sel;
  assign mem_rd      = ctl_w.mem_rd;
  assign mem_wr      = ctl_w.mem_wr;
  assign ir_wr       = ctl_w.ir_wr;
  assign wb_from_mem = ctl_w.wb_from_mem;
  assign dst_sel     = ctl_w.dst_sel;
  assign reg_wr      = ctl_w.reg_wr;
  assign alu_a_sel   = ctl_w.alu_a_sel;
  assign alu_b_sel   = ctl_w.alu_b_sel;
  assign alu_op      = ctl_w.alu_op;
  assign pc_src      = ctl_w.pc_src;
endmodule

// File: rtl/mc_seq_ctrl_chk.sv
module mc_seq_ctrl_chk
  import seqctl_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input ctl_word_t ctl,
  input logic      at_fetch,
  input logic      at_decode,
  input logic      path_end,
  input path_e     dec_path
);
  logic [2:0] cyc_cnt;
  path_e      held_path;
  path_e      cur_path;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_cnt   <= 3'd0;
      held_path <= PATH_NONE;
    end else begin
      cyc_cnt <= path_end ? 3'd0 : cyc_cnt + 3'd1;
      if (at_decode) held_path <= dec_path;
    end
  end

  assign cur_path = at_decode ? dec_path : held_path;

  assert_mem_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(ctl.mem_rd && ctl.mem_wr));

  assert_end_to_fetch_R12: assert property (@(posedge clk) disable iff (rst)
    path_end |=> (ctl.ir_wr && ctl.mem_rd && ctl.pc_wr));

  assert_fetch_first_R12: assert property (@(posedge clk) disable iff (rst)
    at_fetch |-> (cyc_cnt == 3'd0));

  assert_path_len_R12: assert property (@(posedge clk) disable iff (rst)
    path_end |-> ((32'(cyc_cnt) + 32'd1) == path_cycles(cur_path)));

  assert_decode_follows_R3: assert property (@(posedge clk) disable iff (rst)
    at_fetch |=> (ctl.alu_b_sel == BSRC_IMM_SH && !ctl.reg_wr && !ctl.mem_rd && !ctl.pc_wr));

  assert_branch_word_R5: assert property (@(posedge clk) disable iff (rst)
    ctl.pc_wr_cond |-> (ctl.pc_src && ctl.alu_op == AOP_SUB && !ctl.pc_wr));

  assert_rtype_wb_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl.reg_wr && !ctl.wb_from_mem) |-> (ctl.dst_sel && $past(ctl.alu_op) == AOP_FUNCT));

  assert_load_wb_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl.reg_wr && ctl.wb_from_mem) |-> (!ctl.dst_sel && $past(ctl.mem_rd && ctl.addr_sel)));

  assert_store_addr_R7: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_wr |-> (ctl.addr_sel && $past(ctl.alu_b_sel) == BSRC_IMM && $past(ctl.alu_a_sel)));
endmodule

bind mc_seq_ctrl mc_seq_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctl      (ctl_w),
  .at_fetch (at_fetch),
  .at_decode(at_decode),
  .path_end (path_end),
  .dec_path (dec_path)
);

// File: tb/sim_mc_seq_ctrl.sv
module sim_mc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr;
  logic wb_from_mem, dst_sel, reg_wr, alu_a_sel, pc_src;
  logic [1:0] alu_b_sel, alu_op;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mc_seq_ctrl u0 (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
    .wb_from_mem(wb_from_mem), .dst_sel(dst_sel), .reg_wr(reg_wr),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .pc_src(pc_src)
  );

  // kinds: 0 unknown, 1 ALU, 2 load, 3 store, 4 branch
  function automatic int kind_of(logic [5:0] op);
    if (op == 6'd0)  return 1;
    if (op == 6'd35) return 2;
    if (op == 6'd43) return 3;
    if (op == 6'd4)  return 4;
    return 0;
  endfunction

  function automatic int len_of(int k);
    case (k)
      1: return 4;
      2: return 5;
      3: return 4;
      4: return 3;
      default: return 2;
    endcase
  endfunction

  // field order: pc_wr pc_wr_cond addr_sel mem_rd mem_wr ir_wr wb_from_mem dst_sel reg_wr alu_a_sel alu_b_sel alu_op pc_src
  function automatic logic [14:0] mk(bit pw, bit pc, bit ad, bit mr, bit mw, bit ir,
                                     bit wm, bit ds, bit rw, bit as, logic [1:0] bs,
                                     logic [1:0] ao, bit ps);
    return {pw, pc, ad, mr, mw, ir, wm, ds, rw, as, bs, ao, ps};
  endfunction

  function automatic logic [14:0] exp_word(int k, int s);
    if (s == 0) return mk(1,0,0,1,0,1,0,0,0,0,2'b01,2'b00,0);
    if (s == 1) return mk(0,0,0,0,0,0,0,0,0,0,2'b11,2'b00,0);
    case (k)
      1: return (s == 2) ? mk(0,0,0,0,0,0,0,0,0,1,2'b00,2'b10,0)
                         : mk(0,0,0,0,0,0,0,1,1,0,2'b00,2'b00,0);
      4: return mk(0,1,0,0,0,0,0,0,0,1,2'b00,2'b01,1);
      3: return (s == 2) ? mk(0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,0)
                         : mk(0,0,1,0,1,0,0,0,0,0,2'b00,2'b00,0);
      2: begin
        if (s == 2) return mk(0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,0);
        if (s == 3) return mk(0,0,1,1,0,0,0,0,0,0,2'b00,2'b00,0);
        return mk(0,0,0,0,0,0,1,0,1,0,2'b00,2'b00,0);
      end
      default: return 15'd0;
    endcase
  endfunction

  function automatic string tag_of(int k, int s);
    if (s == 0) return "R2,R12";
    if (s == 1) return (k == 0) ? "R3,R10" : "R3";
    case (k)
      1: return "R4,R11";
      4: return "R5,R11";
      3: return (s == 2) ? "R6" : "R7,R11";
      2: return (s == 2) ? "R6" : "R8,R11";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [14:0] got();
    return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_from_mem,
            dst_sel, reg_wr, alu_a_sel, alu_b_sel, alu_op, pc_src};
  endfunction

  task automatic chk(string tag, logic [14:0] act, logic [14:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge; returns at a negedge (or one step after it after an abort).
  task automatic run_op(logic [5:0] op, int abort_at);
    int k;
    k = kind_of(op);
    for (int s = 0; s < len_of(k); s++) begin
      if (s == abort_at) begin
        rst = 1'b1;
        #1 chk("R1", got(), 15'd0);
        @(negedge clk);
        #1 chk("R1", got(), 15'd0);
        rst = 1'b0;
        return;
      end
      // opcode matters only for the edge that ends decode, and the address cycle
      if (s == 1 || (s == 2 && (k == 2 || k == 3)))
        opcode = op;
      else
        opcode = op ^ 6'((s * 13 + 7) & 63) ^ 6'h2a;
      #1;
      chk(tag_of(k, s), got(), exp_word(k, s));
      total++;
      if (mem_rd && mem_wr) begin
        bad++;
        $display("FAIL R9 actual=rd%0b_wr%0b expected=not_both", mem_rd, mem_wr);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    opcode = 6'd35;
    repeat (3) begin
      @(negedge clk);
      #1 chk("R1", got(), 15'd0);
    end
    @(negedge clk);
    rst = 1'b0;
    // sweep every opcode through its full path
    for (int op = 0; op < 64; op++) run_op(6'(op), -1);
    // back-to-back known instructions in varied order
    run_op(6'd35, -1); run_op(6'd35, -1); run_op(6'd43, -1);
    run_op(6'd4, -1);  run_op(6'd0, -1);  run_op(6'd4, -1);
    // reset dropped into a load before its memory read, and into a branch decode
    run_op(6'd35, 3);
    run_op(6'd43, -1);
    run_op(6'd4, 1);
    run_op(6'd0, -1);
    run_op(6'd35, -1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule